// File: doc/BRIEF.md
# Lazy Processor Status Flag Unit

This block holds the status flags of a small 8-bit accumulator core and performs the flag-producing arithmetic for it. A request carries an operation class, the accumulator value, a memory operand and, for a pull, a status byte. One cycle later the block returns the arithmetic result, the assembled status byte and, for branch requests, the branch decision.

Negative and zero are never held as flag bits. Every operation that affects them copies its result into a shadow register, and both conditions are read from that register only when a branch or a status push needs them. Carry, interrupt-disable, decimal and overflow are held as plain bits. A pull rebuilds the shadow value so that it reproduces the pulled negative and zero conditions. Addition and subtraction are always binary, whatever the decimal bit holds.

Top module: `lazy_flag_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid` and `rsp_taken` are 0, and the state is C=0, I=1, D=0, V=0, with negative and zero both clear.
- R2: Operation code 1 (add) returns A + M + C as an 8-bit sum. C becomes the carry out, and the sum becomes the new zero/negative source.
- R3: For add and subtract, V becomes bit 7 of ((A xor S) and (M' xor S)), where S is the sum and M' is the operand as it was added.
- R4: Operation code 2 (subtract) behaves as add with the operand inverted. C acts as an inverted borrow.
- R5: When A is 0xFF and the carry-in is 1, an add or subtract returns the (possibly inverted) operand, forces V to 0 and leaves C at 1.
- R6: Operation code 3 (compare) returns A − M. It sets C to (A ≥ M) and sets the zero/negative source to the difference. V is left unchanged.
- R7: Operation code 4 (load/logic result) takes the operand as the new zero/negative source and returns it. C and V are left unchanged.
- R8: Operation codes 8, 9, 10 and 11 set `rsp_taken` when, respectively, the value is zero, non-zero, bit 7 is set, or bit 7 is clear. `rsp_taken` is 0 for every other code.
- R9: `rsp_psw` is {N,V,1,B,D,I,Z,C} (bit 7 down to bit 0), taken after the operation. B is 0 only for operation code 7 (hardware interrupt push); operation code 6 (software push) and all other codes give B=1.
- R10: Operation code 5 (pull) loads C, Z, I, D, V and N from `req_data` bits 0, 1, 2, 3, 6 and 7. If bits 1 and 7 are both set, zero wins and N reads back 0.
- R11: A set D bit is kept across adds. The sum stays binary (0x09 + 0x01 gives 0x0A).
- R12: Every request, and only a request, produces `rsp_valid` exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation class code |
| req_a | input | W | Accumulator or register value |
| req_m | input | W | Memory operand |
| req_data | input | 8 | Status byte for a pull |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_result | output | W | Sum, difference or loaded value |
| rsp_psw | output | 8 | Assembled status byte after the operation |
| rsp_taken | output | 1 | Branch decision |

## Verification
The bench builds the block with the default width W=8, the only width for which the status byte layout and the byte-wide overflow rules mean anything. At this width the corner values are reachable with directed requests: 0xFF plus carry, the signed overflows 0x50+0x50 and 0x80−0x01, and a pull with negative and zero both set. A long random run of mixed requests then covers sequences in which the shadow value is stale, rebuilt, or read by a branch straight after a pull.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_ADC     = 4'd1,
    OP_SBC     = 4'd2,
    OP_CMP     = 4'd3,
    OP_LOAD    = 4'd4,
    OP_PULL    = 4'd5,
    OP_PUSH_SW = 4'd6,
    OP_PUSH_HW = 4'd7,
    OP_BEQ     = 4'd8,
    OP_BNE     = 4'd9,
    OP_BMI     = 4'd10,
    OP_BPL     = 4'd11
  } sf_op_e;

  localparam int PSW_C = 0;
  localparam int PSW_Z = 1;
  localparam int PSW_I = 2;
  localparam int PSW_D = 3;
  localparam int PSW_B = 4;
  localparam int PSW_U = 5;
  localparam int PSW_V = 6;
  localparam int PSW_N = 7;
endpackage

// File: rtl/sf_alu.sv
module sf_alu #(
  parameter int W = 8
) (
  input  sf_pkg::sf_op_e op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           vout
);
  import sf_pkg::*;
  localparam int MSB = W - 1;

  logic         inv;
  logic         ci;
  logic [W-1:0] mx;
  logic [W:0]   wide;

  always_comb begin
    inv  = (op == OP_SBC) || (op == OP_CMP);
    ci   = (op == OP_CMP) ? 1'b1 : cin;
    mx   = inv ? ~m : m;
    wide = {1'b0, a} + {1'b0, mx} + {{W{1'b0}}, ci};
    if ((op != OP_CMP) && ci && (&a)) begin
      // accumulator plus carry wraps to zero: operand passes through
      res  = mx;
      cout = ci;
      vout = 1'b0;
    end else begin
      res  = wide[W-1:0];
      cout = wide[W];
      vout = (a[MSB] ^ wide[MSB]) & (mx[MSB] ^ wide[MSB]);
    end
  end
endmodule

// File: rtl/sf_branch.sv
module sf_branch #(
  parameter int W = 8
) (
  input  sf_pkg::sf_op_e op,
  input  logic [W-1:0]   shadow,
  output logic           taken
);
  import sf_pkg::*;
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (shadow == '0);
    is_neg  = shadow[W-1];
    unique case (op)
      OP_BEQ:  taken = is_zero;
      OP_BNE:  taken = !is_zero;
      OP_BMI:  taken = is_neg;
      OP_BPL:  taken = !is_neg;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/sf_pack.sv
module sf_pack #(
  parameter int W = 8
) (
  input  logic [W-1:0] shadow,
  input  logic         c,
  input  logic         i,
  input  logic         d,
  input  logic         v,
  input  logic         brk,
  output logic [7:0]   psw
);
  import sf_pkg::*;
  always_comb begin
    psw        = '0;
    psw[PSW_C] = c;
    psw[PSW_Z] = (shadow == '0);
    psw[PSW_I] = i;
    psw[PSW_D] = d;
    psw[PSW_B] = brk;
    psw[PSW_U] = 1'b1;
    psw[PSW_V] = v;
    psw[PSW_N] = shadow[W-1];
  end
endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [3:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_m,
  input  logic [7:0]   req_data,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_result,
  output logic [7:0]   rsp_psw,
  output logic         rsp_taken
);
  import sf_pkg::*;

  localparam logic [W-1:0] SHADOW_RST = {{(W-1){1'b0}}, 1'b1};

  sf_op_e       op;
  logic         c_q, i_q, d_q, v_q;
  logic [W-1:0] q_q;
  logic         c_n, i_n, d_n, v_n;
  logic [W-1:0] q_n;
  logic [W-1:0] alu_res;
  logic         alu_c, alu_v;
  logic         br_taken;
  logic [7:0]   psw_n;
  logic [W-1:0] res_n;

  assign op = sf_op_e'(req_op);

  sf_alu #(.W(W)) u_alu (
    .op(op), .a(req_a), .m(req_m), .cin(c_q),
    .res(alu_res), .cout(alu_c), .vout(alu_v)
  );

  sf_branch #(.W(W)) u_branch (
    .op(op), .shadow(q_q), .taken(br_taken)
  );

  always_comb begin
    c_n   = c_q;
    i_n   = i_q;
    d_n   = d_q;
    v_n   = v_q;
    q_n   = q_q;
    res_n = '0;
    if (req_valid) begin
      unique case (op)
        OP_ADC, OP_SBC: begin
          c_n   = alu_c;
          v_n   = alu_v;
          q_n   = alu_res;
          res_n = alu_res;
        end
        OP_CMP: begin
          c_n   = alu_c;
          q_n   = alu_res;
          res_n = alu_res;
        end
        OP_LOAD: begin
          q_n   = req_m;
          res_n = req_m;
        end
        OP_PULL: begin
          c_n = req_data[PSW_C];
          i_n = req_data[PSW_I];
          d_n = req_data[PSW_D];
          v_n = req_data[PSW_V];
          if (req_data[PSW_Z]) q_n = '0;
          else q_n = {req_data[PSW_N], {(W-2){1'b0}}, 1'b1};
        end
        default: ;
      endcase
    end
  end

  sf_pack #(.W(W)) u_pack (
    .shadow(q_n), .c(c_n), .i(i_n), .d(d_n), .v(v_n),
    .brk(op != OP_PUSH_HW), .psw(psw_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q        <= 1'b0;
      i_q        <= 1'b1;
      d_q        <= 1'b0;
      v_q        <= 1'b0;
      q_q        <= SHADOW_RST;
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
      rsp_psw    <= '0;
      rsp_taken  <= 1'b0;
    end else begin
      c_q       <= c_n;
      i_q       <= i_n;
      d_q       <= d_n;
      v_q       <= v_n;
      q_q       <= q_n;
      rsp_valid <= req_valid;
      rsp_taken <= req_valid && br_taken;
      if (req_valid) begin
        rsp_result <= res_n;
        rsp_psw    <= psw_n;
      end
    end
  end
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic [3:0]   req_op,
  input logic [7:0]   req_data,
  input logic         rsp_valid,
  input logic [7:0]   rsp_psw,
  input logic         rsp_taken,
  input logic         v_q,
  input logic         d_q,
  input logic [W-1:0] q_q
);
  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_cmp_keeps_v_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd3) |=> (v_q == $past(v_q)));
  assert_adc_keeps_d_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd1) |=> $stable(d_q));
  assert_hw_push_no_b_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd7) |=> (!rsp_psw[4] && rsp_psw[5]));
  assert_pull_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd5 && req_data[1]) |=> (q_q == '0));
  assert_taken_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_taken |-> rsp_valid);
endmodule

bind lazy_flag_unit sf_checker #(.W(W)) u_sf_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_data(req_data), .rsp_valid(rsp_valid), .rsp_psw(rsp_psw),
  .rsp_taken(rsp_taken), .v_q(v_q), .d_q(d_q), .q_q(q_q)
);

// File: tb/test_lazy_flag_unit.sv
module test_lazy_flag_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [3:0]   req_op = '0;
  logic [W-1:0] req_a = '0;
  logic [W-1:0] req_m = '0;
  logic [7:0]   req_data = '0;
  logic         rsp_valid;
  logic [W-1:0] rsp_result;
  logic [7:0]   rsp_psw;
  logic         rsp_taken;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state kept as individual flags
  bit mc, mz, mi, md, mv, mn;
  int exp_res;
  int exp_psw;
  bit exp_tk;

  always #5 clk = ~clk;

  lazy_flag_unit #(.W(W)) i_lazy_flag_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_a(req_a), .req_m(req_m), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result),
    .rsp_psw(rsp_psw), .rsp_taken(rsp_taken)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(int op, int a, int m, int d);
    int s;
    int mx;
    exp_res = -1;
    exp_tk  = 0;
    case (op)
      1, 2: begin
        mx = (op == 2) ? (~m & 255) : m;
        s = a + mx + (mc ? 1 : 0);
        exp_res = s & 255;
        mc = (s > 255);
        mv = (((a ^ exp_res) & (mx ^ exp_res) & 128) != 0);
        mz = (exp_res == 0);
        mn = exp_res[7];
      end
      3: begin
        exp_res = (a - m) & 255;
        mc = (a >= m);
        mz = (exp_res == 0);
        mn = exp_res[7];
      end
      4: begin
        exp_res = m;
        mz = (m == 0);
        mn = m[7];
      end
      5: begin
        mc = d[0]; mz = d[1]; mi = d[2]; md = d[3]; mv = d[6];
        mn = d[7] && !d[1];
      end
      8:  exp_tk = mz;
      9:  exp_tk = !mz;
      10: exp_tk = mn;
      11: exp_tk = !mn;
      default: ;
    endcase
    exp_psw = {mn, mv, 1'b1, (op != 7), md, mi, mz, mc};
  endfunction

  task automatic step(string req, int op, int a, int m, int d);
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op[3:0];
    req_a = a[7:0];
    req_m = m[7:0];
    req_data = d[7:0];
    model(op, a, m, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " R12 valid"}, rsp_valid, 1);
    chk({req, " R9 psw"}, rsp_psw, exp_psw);
    chk({req, " R8 taken"}, rsp_taken, exp_tk);
    if (exp_res >= 0) chk({req, " result"}, rsp_result, exp_res);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mc = 0; mz = 0; mi = 1; md = 0; mv = 0; mn = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 rsp_taken after reset", rsp_taken, 0);
    @(negedge clk);
    chk("R12 idle no response", rsp_valid, 0);

    step("R1 R9 software push", 6, 0, 0, 0);
    chk("R9 software push byte", rsp_psw, 8'h34);
    step("R9 hardware push", 7, 0, 0, 0);
    chk("R9 hardware push byte", rsp_psw, 8'h24);

    step("R10 pull N and Z", 5, 0, 0, 8'hFF);
    chk("R10 zero wins", rsp_psw, 8'h7F);
    step("R10 BEQ after pull", 8, 0, 0, 0);
    step("R10 BMI after pull", 10, 0, 0, 0);
    step("R10 pull N only", 5, 0, 0, 8'h80);
    step("R10 BMI after N pull", 10, 0, 0, 0);

    step("R2 R3 add overflow", 1, 8'h50, 8'h50, 0);
    chk("R3 0x50+0x50 sum", rsp_result, 8'hA0);
    step("R2 add wrap", 1, 8'hFF, 8'h01, 0);
    chk("R2 carry out psw", rsp_psw[0], 1);
    step("R5 A=FF cin=1", 1, 8'hFF, 8'h80, 0);
    chk("R5 V forced 0", rsp_psw[6], 0);
    chk("R5 C kept", rsp_psw[0], 1);
    step("R4 sub no borrow overflow", 2, 8'h80, 8'h01, 0);
    chk("R4 0x80-0x01", rsp_result, 8'h7F);
    step("R4 sub borrow", 2, 8'h50, 8'hF0, 0);
    chk("R4 borrow clears C", rsp_psw[0], 0);

    step("R6 set V via pull", 5, 0, 0, 8'h41);
    step("R6 compare equal", 3, 8'h33, 8'h33, 0);
    chk("R6 V unchanged", rsp_psw[6], 1);
    step("R6 compare less", 3, 8'h10, 8'h20, 0);
    step("R6 compare greater", 3, 8'h90, 8'h20, 0);

    step("R7 load negative", 4, 0, 8'h80, 0);
    step("R8 BEQ", 8, 0, 0, 0);
    step("R8 BNE", 9, 0, 0, 0);
    step("R8 BMI", 10, 0, 0, 0);
    step("R8 BPL", 11, 0, 0, 0);
    step("R7 load zero", 4, 0, 8'h00, 0);
    step("R8 BEQ zero", 8, 0, 0, 0);
    step("R8 BPL zero", 11, 0, 0, 0);

    step("R11 set D", 5, 0, 0, 8'h08);
    step("R11 binary add", 1, 8'h09, 8'h01, 0);
    chk("R11 D kept", rsp_psw[3], 1);

    for (int k = 0; k < 400; k++) begin
      int op;
      op = 1 + int'($urandom_range(10));
      step("R2-random mix", op, int'($urandom_range(255)),
           int'($urandom_range(255)), int'($urandom_range(255)));
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        chk("R12 random idle", rsp_valid, 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule